// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block records when an external signal changes. It takes a 16-bit timer value from a free-running counter outside the block. When the monitored pin makes a qualifying transition, the block copies that timer value into a capture register and raises a sticky interrupt flag. The raw pin first passes through a two-stage synchronizer.

An optional digital glitch filter can be placed after the synchronizer. With the filter on, the block accepts a new level only after the level has been seen on four consecutive synchronized samples. Shorter pulses are discarded.

A two-bit field selects which transitions count as events: rising edges, falling edges, both, or none. An event prescaler lets a set number of qualified events pass before a capture happens. This allows software to timestamp, for example, every fourth rising edge. Timer generation and register decoding stay outside the block.

Top module: `edge_stamp_capture`

## Requirements
- R1: After synchronous reset, `cap_val` reads 0, `cap_irq` reads 0, the filtered level is low and the event counter is 0.
- R2: With `filt_en` = 0, a single synchronized sample of a new level is recognised as an edge. A pin change applied just before clock edge k latches the timer value present at edge k+3.
- R3: With `filt_en` = 1, a new level is accepted only after four consecutive synchronized samples show it. A pin pulse of 1 to 3 cycles causes no capture. A change held long enough latches the timer value present at edge k+6.
- R4: `edge_sel` encoding: 2'b01 selects rising edges only, 2'b10 selects falling edges only, 2'b11 selects both, and 2'b00 selects no events.
- R5: With `evt_count` = N, a capture happens on every (N+1)-th qualified event. The event counter reloads to 0 at each capture.
- R6: `cap_val` changes only on a capture and otherwise holds its last value.
- R7: `cap_irq` is set by a capture and stays set until a cycle with `irq_clr` = 1 clears it.
- R8: When a capture and `irq_clr` = 1 fall in the same cycle, the flag ends up set.
- R9: If `evt_count` is lowered to or below the number of events already counted, the next qualified event captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_val | input | 16 | Free-running timer value to be captured |
| pin_raw | input | 1 | Asynchronous input pin being monitored |
| filt_en | input | 1 | Enables the four-sample glitch filter |
| edge_sel | input | 2 | Event polarity select (see R4) |
| evt_count | input | 4 | Number of qualified events skipped before each capture |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| cap_val | output | 16 | Captured timer value |
| cap_irq | output | 1 | Sticky capture interrupt flag |

## Verification
Most internal faults show up as a wrong number in `cap_val` within six cycles of the pin change that should have been captured. A filter or synchronizer depth error shifts every captured timestamp by a fixed amount. A fault in the edge qualification or the event counter shows as a flag that rises on the wrong transition of a pulse train, or does not rise at all. The sweep covers every edge mode, both filter settings and several prescale counts. Within one train it exposes a counter that miscounts, fails to reload, or compares wrongly when its limit is lowered.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Qualify a detected transition against the selected polarity mode
    function automatic logic edge_match(edge_mode_e mode, edge_ev_t ev);
        return (mode[0] & ev.rise) | (mode[1] & ev.fall);
    endfunction

endpackage

// File: rtl/ecap_filter.sv
module ecap_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sync_in,
    output logic level
);
    localparam int HIST_W = FILT_LEN - 1;

    logic [HIST_W-1:0]   hist;
    logic [FILT_LEN-1:0] window;
    logic                all_hi;
    logic                all_lo;

    assign window = {hist, sync_in};
    assign all_hi = &window;
    assign all_lo = ~|window;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            level <= 1'b0;
        end else begin
            hist <= window[FILT_LEN-2:0];
            if (!en)
                level <= sync_in;
            else if (all_hi)
                level <= 1'b1;
            else if (all_lo)
                level <= 1'b0;
        end
    end

    // R3
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(level)) |->
            ($past(sync_in, 1) == level && $past(sync_in, 2) == level));

endmodule

// File: rtl/ecap_edge_det.sv
module ecap_edge_det
    import ecap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  edge_mode_e mode,
    output logic       evt
);
    logic     prev;
    edge_ev_t ev;

    assign ev.rise = level & ~prev;
    assign ev.fall = ~level & prev;
    assign evt     = edge_match(mode, ev);

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    // R4
    edge_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && mode == EDGE_RISE) |-> level);

    // R4
    edge_none_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EDGE_NONE) |-> !evt);

endmodule

// File: rtl/ecap_prescaler.sv
module ecap_prescaler #(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic [EVT_W-1:0] limit,
    output logic             fire
);
    logic [EVT_W-1:0] cnt;

    assign fire = evt && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (fire) cnt <= '0;
        else if (evt)  cnt <= cnt + 1'b1;
    end

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt == '0));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !fire) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
    import ecap_pkg::*;
#(
    parameter int TIMER_W  = 16,
    parameter int EVT_W    = 4,
    parameter int FILT_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIMER_W-1:0] timer_val,
    input  logic               pin_raw,
    input  logic               filt_en,
    input  logic [1:0]         edge_sel,
    input  logic [EVT_W-1:0]   evt_count,
    input  logic               irq_clr,
    output logic [TIMER_W-1:0] cap_val,
    output logic               cap_irq
);
    logic [1:0] sync_q;
    logic       level;
    logic       evt;
    logic       fire;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], pin_raw};
    end

    ecap_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .rst(rst), .en(filt_en), .sync_in(sync_q[1]), .level(level)
    );

    ecap_edge_det u_edge (
        .clk(clk), .rst(rst), .level(level),
        .mode(edge_mode_e'(edge_sel)), .evt(evt)
    );

    ecap_prescaler #(.EVT_W(EVT_W)) u_presc (
        .clk(clk), .rst(rst), .evt(evt), .limit(evt_count), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
            cap_irq <= 1'b0;
        end else begin
            if (fire) cap_val <= timer_val;
            if (fire)         cap_irq <= 1'b1;
            else if (irq_clr) cap_irq <= 1'b0;
        end
    end

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cap_val));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> cap_irq);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_irq && !irq_clr) |=> cap_irq);

endmodule

// File: tb/test_edge_stamp_capture.sv
module test_edge_stamp_capture;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] timer_val;
    logic        pin_raw;
    logic        filt_en;
    logic [1:0]  edge_sel;
    logic [3:0]  evt_count;
    logic        irq_clr;
    logic [15:0] cap_val;
    logic        cap_irq;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign timer_val = cyc[15:0];

    edge_stamp_capture i_edge_stamp_capture (
        .clk(clk), .rst(rst), .timer_val(timer_val), .pin_raw(pin_raw),
        .filt_en(filt_en), .edge_sel(edge_sel), .evt_count(evt_count),
        .irq_clr(irq_clr), .cap_val(cap_val), .cap_irq(cap_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin_raw = 1'b0; irq_clr = 1'b0;
        wait_n(3);
        rst = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int t;
        int lat;
        int nq;
        int last_cap;
        bit fire;
        bit rising;
        rst = 1'b1; pin_raw = 1'b0; irq_clr = 1'b0;
        filt_en = 1'b0; edge_sel = 2'b01; evt_count = '0;

        // R1 reset state
        do_reset();
        wait_n(1);
        check("R1 cap_val", int'(cap_val), 0);
        check("R1 cap_irq", int'(cap_irq), 0);

        // Sweep R2 R3 R4 R5 R6 R7 over mode, filter, prescale
        for (int sel = 0; sel < 4; sel++) begin
            for (int f = 0; f < 2; f++) begin
                for (int ev = 0; ev < 4; ev++) begin
                    filt_en = f[0]; edge_sel = sel[1:0]; evt_count = ev[3:0];
                    do_reset();
                    lat = f ? 6 : 3;
                    nq = 0; last_cap = 0;
                    for (int k = 0; k < 8; k++) begin
                        clear_flag();
                        wait_n(1);
                        pin_raw = ~pin_raw;
                        rising = pin_raw;
                        t = int'(cyc);
                        wait_n(9);
                        fire = 1'b0;
                        if ((rising && sel[0]) || (!rising && sel[1])) begin
                            if (nq >= ev) begin fire = 1'b1; nq = 0; end
                            else nq++;
                        end
                        if (fire) last_cap = (t + lat) & 16'hFFFF;
                        check("R4/R5/R7 flag", int'(cap_irq), int'(fire));
                        check(f ? "R3/R6 cap_val" : "R2/R6 cap_val", int'(cap_val), last_cap);
                    end
                end
            end
        end

        // R3 glitch filter: pulses of width 1..5
        filt_en = 1'b1; edge_sel = 2'b01; evt_count = '0;
        for (int w = 1; w <= 5; w++) begin
            do_reset();
            wait_n(1);
            pin_raw = 1'b1; t = int'(cyc);
            wait_n(w);
            pin_raw = 1'b0;
            wait_n(10);
            check("R3 glitch flag", int'(cap_irq), (w >= 4) ? 1 : 0);
            check("R3 glitch cap", int'(cap_val), (w >= 4) ? ((t + 6) & 16'hFFFF) : 0);
        end

        // R2 one-cycle pulse unfiltered, both edges
        filt_en = 1'b0; edge_sel = 2'b11; evt_count = '0;
        do_reset();
        wait_n(1);
        pin_raw = 1'b1; t = int'(cyc);
        wait_n(1);
        pin_raw = 1'b0;
        wait_n(8);
        check("R2 short pulse flag", int'(cap_irq), 1);
        check("R2 short pulse cap", int'(cap_val), (t + 4) & 16'hFFFF);

        // R8 capture and clear in the same cycle
        edge_sel = 2'b01;
        do_reset();
        wait_n(1);
        pin_raw = 1'b1; t = int'(cyc);
        wait_n(3);
        irq_clr = 1'b1;
        wait_n(1);
        irq_clr = 1'b0;
        wait_n(2);
        check("R8 set over clear", int'(cap_irq), 1);
        check("R8 cap", int'(cap_val), (t + 3) & 16'hFFFF);
        clear_flag();
        wait_n(1);
        check("R7 clear", int'(cap_irq), 0);

        // R9 limit lowered below events counted
        edge_sel = 2'b11; evt_count = 4'd3;
        do_reset();
        for (int k = 0; k < 2; k++) begin
            wait_n(1);
            pin_raw = ~pin_raw;
            wait_n(6);
        end
        check("R9 no capture yet", int'(cap_irq), 0);
        evt_count = 4'd1;
        wait_n(1);
        pin_raw = ~pin_raw; t = int'(cyc);
        wait_n(6);
        check("R9 flag", int'(cap_irq), 1);
        check("R9 cap", int'(cap_val), (t + 3) & 16'hFFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule